// File: doc/BRIEF.md
# Quick-Branch Next-PC Unit

This block decides where a word-addressed instruction stream goes next. For each instruction it takes the current program counter, a 4-bit flow-control code, the first source value, a second source value, an immediate field, an immediate-select bit and a signed branch offset. From these it produces the following program counter and a taken flag. For jump-and-link it also produces a return address and a write strobe for the destination register. Comparisons and bit tests are computed inside the block.

The second operand is either the register value or an immediate. For relative branches the immediate is its low 8 bits, zero-extended. For absolute jumps it is the full 16-bit immediate. Every conditional test is phrased as "second operand versus first source", which is the reverse of the usual order. A taken relative branch adds the sign-extended offset to the current PC. Anything not taken falls through to PC+1.

The block is purely combinational and holds no state. It does not fetch instructions and does not contain the register file.

Top module: `qb_next_pc`

## Requirements
- R1: Opcode codes 0 and 12 to 15 are not flow control. They give pc_next = pc_cur+1, br_taken = 0 and link_we = 0.
- R2: Ordered branches use unsigned 32-bit comparison and are taken when the condition holds: code 1 when op2 > rs1, code 2 when op2 >= rs1, code 3 when op2 < rs1, code 4 when op2 <= rs1.
- R3: Code 5 is taken when op2 == rs1. Code 6 is taken when op2 != rs1.
- R4: Code 7 is always taken, for every operand value.
- R5: A taken relative branch gives pc_next = pc_cur + sign-extended br_ofs. A not-taken one gives pc_cur+1. Both wrap modulo 2^16.
- R6: Code 8 is taken when bit (op2 & 0x1F) of rs1 is 1. Code 9 is taken when that bit is 0. The upper bits of op2 play no part in the test.
- R7: For codes 1 to 9, op2 is imm_val[7:0] zero-extended when imm_sel = 1, and rs2_val when imm_sel = 0. imm_val[15:8] has no effect on these codes.
- R8: Code 10 is an absolute jump. It is always taken, and pc_next = imm_val when imm_sel = 1, or rs2_val[15:0] when imm_sel = 0. link_we stays 0.
- R9: Code 11 jumps to the same target as code 10. It also sets link_we = 1 and link_val = pc_cur+1 zero-extended to 32 bits. link_we is 0 for every other code.
- R10: br_ofs is a 10-bit two's-complement value, so an offset with its top bit set moves the PC backwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_cur | input | 16 | Current program counter (word address) |
| op_code | input | 4 | Flow-control code (see R1 to R9) |
| rs1_val | input | 32 | First source value |
| rs2_val | input | 32 | Second source register value |
| imm_val | input | 16 | Immediate field |
| imm_sel | input | 1 | Selects the immediate as second operand |
| br_ofs | input | 10 | Signed relative branch offset |
| pc_next | output | 16 | Following program counter |
| br_taken | output | 1 | Flow leaves the sequential path |
| link_val | output | 32 | Return address for jump-and-link |
| link_we | output | 1 | Destination write strobe for jump-and-link |

## Verification
All sixteen codes are swept against first-source values and second-operand values that sit just below, at and just above one another. These include zero, the top bit alone and all ones, so greater-than and greater-or-equal are separated, and signed comparison can be told apart from unsigned. Each vector is applied with both immediate-select settings, using immediates whose upper byte disagrees with the register value, which shows which operand reached the comparator. Positive, negative and extreme offsets at low, middle and top PC values expose sign-extension and wrap errors. A sweep over all 32 bit positions, with junk in the upper index bits, separates bit-set from bit-clear and shows that the index is masked.

// File: rtl/qb_pkg.sv
package qb_pkg;

    typedef enum logic [3:0] {
        OP_OTHER = 4'd0,
        OP_BGT   = 4'd1,
        OP_BGE   = 4'd2,
        OP_BLT   = 4'd3,
        OP_BLE   = 4'd4,
        OP_BEQ   = 4'd5,
        OP_BNE   = 4'd6,
        OP_BALW  = 4'd7,
        OP_BBS   = 4'd8,
        OP_BBC   = 4'd9,
        OP_JMP   = 4'd10,
        OP_JAL   = 4'd11
    } qb_op_e;

    localparam int unsigned QB_OP_W = 4;

endpackage

// File: rtl/qb_operand_sel.sv
module qb_operand_sel
    import qb_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned IMM_W    = 16,
    parameter int unsigned BR_IMM_W = 8
) (
    input  logic [DATA_W-1:0] rs2_val,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic              imm_sel,
    input  logic              is_jump,
    output logic [DATA_W-1:0] op2_val
);

    localparam int unsigned JPAD_W = DATA_W - IMM_W;
    localparam int unsigned BPAD_W = DATA_W - BR_IMM_W;

    logic [DATA_W-1:0] br_imm_ext;
    logic [DATA_W-1:0] jmp_imm_ext;

    assign br_imm_ext  = {{BPAD_W{1'b0}}, imm_val[BR_IMM_W-1:0]};
    assign jmp_imm_ext = {{JPAD_W{1'b0}}, imm_val};

    always_comb begin
        if (!imm_sel) begin
            op2_val = rs2_val;
        end else if (is_jump) begin
            op2_val = jmp_imm_ext;
        end else begin
            op2_val = br_imm_ext;
        end
    end

    always_comb begin
        if (imm_sel && !is_jump) begin
            AST_BR_IMM_NARROW: assert (op2_val[DATA_W-1:BR_IMM_W] == '0); // R7
        end
    end

endmodule

// File: rtl/qb_cond_eval.sv
module qb_cond_eval
    import qb_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [QB_OP_W-1:0] op_code,
    input  logic [DATA_W-1:0]  rs1_val,
    input  logic [DATA_W-1:0]  op2_val,
    output logic               cond_take
);

    localparam int unsigned IDX_W = $clog2(DATA_W);

    logic [IDX_W-1:0] bit_idx;
    logic             bit_hit;
    logic             op_gt;
    logic             op_eq;

    assign bit_idx = op2_val[IDX_W-1:0];
    assign bit_hit = rs1_val[bit_idx];
    assign op_gt   = op2_val > rs1_val;
    assign op_eq   = op2_val == rs1_val;

    always_comb begin
        case (op_code)
            OP_BGT:  cond_take = op_gt;
            OP_BGE:  cond_take = op_gt | op_eq;
            OP_BLT:  cond_take = ~(op_gt | op_eq);
            OP_BLE:  cond_take = ~op_gt;
            OP_BEQ:  cond_take = op_eq;
            OP_BNE:  cond_take = ~op_eq;
            OP_BALW: cond_take = 1'b1;
            OP_BBS:  cond_take = bit_hit;
            OP_BBC:  cond_take = ~bit_hit;
            default: cond_take = 1'b0;
        endcase
    end

    always_comb begin
        if (op_code == OP_BEQ && rs1_val == op2_val) begin
            AST_EQ_TAKES: assert (cond_take); // R3
        end
    end

endmodule

// File: rtl/qb_target_gen.sv
module qb_target_gen #(
    parameter int unsigned PC_W  = 16,
    parameter int unsigned OFS_W = 10
) (
    input  logic [PC_W-1:0]  pc_cur,
    input  logic [OFS_W-1:0] br_ofs,
    input  logic             rel_take,
    input  logic             is_jump,
    input  logic [PC_W-1:0]  jump_tgt,
    output logic [PC_W-1:0]  seq_pc,
    output logic [PC_W-1:0]  pc_next
);

    localparam int unsigned SX_W = PC_W - OFS_W;

    logic [PC_W-1:0] ofs_ext;
    logic [PC_W-1:0] rel_pc;

    assign ofs_ext = {{SX_W{br_ofs[OFS_W-1]}}, br_ofs};
    assign seq_pc  = pc_cur + PC_W'(1);
    assign rel_pc  = pc_cur + ofs_ext;

    always_comb begin
        if (is_jump) begin
            pc_next = jump_tgt;
        end else if (rel_take) begin
            pc_next = rel_pc;
        end else begin
            pc_next = seq_pc;
        end
    end

endmodule

// File: rtl/qb_next_pc.sv
module qb_next_pc
    import qb_pkg::*;
#(
    parameter int unsigned PC_W   = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IMM_W  = 16,
    parameter int unsigned OFS_W  = 10
) (
    input  logic [PC_W-1:0]    pc_cur,
    input  logic [QB_OP_W-1:0] op_code,
    input  logic [DATA_W-1:0]  rs1_val,
    input  logic [DATA_W-1:0]  rs2_val,
    input  logic [IMM_W-1:0]   imm_val,
    input  logic               imm_sel,
    input  logic [OFS_W-1:0]   br_ofs,
    output logic [PC_W-1:0]    pc_next,
    output logic               br_taken,
    output logic [DATA_W-1:0]  link_val,
    output logic               link_we
);

    localparam int unsigned LPAD_W = DATA_W - PC_W;

    logic              is_jump;
    logic [DATA_W-1:0] op2_val;
    logic              cond_take;
    logic [PC_W-1:0]   seq_pc;

    assign is_jump = (op_code == OP_JMP) || (op_code == OP_JAL);

    qb_operand_sel #(
        .DATA_W   (DATA_W),
        .IMM_W    (IMM_W),
        .BR_IMM_W (8)
    ) u_opsel (
        .rs2_val (rs2_val),
        .imm_val (imm_val),
        .imm_sel (imm_sel),
        .is_jump (is_jump),
        .op2_val (op2_val)
    );

    qb_cond_eval #(
        .DATA_W (DATA_W)
    ) u_cond (
        .op_code   (op_code),
        .rs1_val   (rs1_val),
        .op2_val   (op2_val),
        .cond_take (cond_take)
    );

    qb_target_gen #(
        .PC_W  (PC_W),
        .OFS_W (OFS_W)
    ) u_tgt (
        .pc_cur   (pc_cur),
        .br_ofs   (br_ofs),
        .rel_take (cond_take),
        .is_jump  (is_jump),
        .jump_tgt (op2_val[PC_W-1:0]),
        .seq_pc   (seq_pc),
        .pc_next  (pc_next)
    );

    assign br_taken = is_jump | cond_take;
    assign link_we  = (op_code == OP_JAL);
    assign link_val = {{LPAD_W{1'b0}}, seq_pc};

    always_comb begin
        if (!br_taken) begin
            AST_FALLTHROUGH: assert (pc_next == pc_cur + PC_W'(1)); // R5
        end
        if (link_we) begin
            AST_LINK_TAKEN: assert (br_taken); // R9
            AST_LINK_RET: assert (link_val[PC_W-1:0] == pc_cur + PC_W'(1)); // R9
        end
        if (op_code == OP_BALW) begin
            AST_ALWAYS_TAKEN: assert (br_taken); // R4
        end
        if (op_code > OP_JAL || op_code == OP_OTHER) begin
            AST_OTHER_QUIET: assert (!br_taken && !link_we); // R1
        end
    end

endmodule

// File: tb/test_qb_next_pc.sv
module test_qb_next_pc;

    logic        clk;
    logic [15:0] pc_cur;
    logic [3:0]  op_code;
    logic [31:0] rs1_val;
    logic [31:0] rs2_val;
    logic [15:0] imm_val;
    logic        imm_sel;
    logic [9:0]  br_ofs;
    logic [15:0] pc_next;
    logic        br_taken;
    logic [31:0] link_val;
    logic        link_we;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 0;

    qb_next_pc i_qb_next_pc (
        .pc_cur   (pc_cur),
        .op_code  (op_code),
        .rs1_val  (rs1_val),
        .rs2_val  (rs2_val),
        .imm_val  (imm_val),
        .imm_sel  (imm_sel),
        .br_ofs   (br_ofs),
        .pc_next  (pc_next),
        .br_taken (br_taken),
        .link_val (link_val),
        .link_we  (link_we)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests = n_tests + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: op=%0d pc=%h rs1=%h rs2=%h imm=%h sel=%0d ofs=%h actual=%h expected=%h",
                     tag, what, op_code, pc_cur, rs1_val, rs2_val, imm_val, imm_sel, br_ofs, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd1, 4'd2, 4'd3, 4'd4: return "R2";
            4'd5, 4'd6:             return "R3";
            4'd7:                   return "R4";
            4'd8, 4'd9:             return "R6";
            4'd10:                  return "R8";
            4'd11:                  return "R9";
            default:                return "R1";
        endcase
    endfunction

    task automatic apply_and_check(input logic [15:0] pc, input logic [3:0] op, input logic [31:0] r1,
                                   input logic [31:0] r2, input logic [15:0] im, input logic sel,
                                   input logic [9:0] ofs, input string tag);
        logic [31:0] op2;
        logic        tk;
        logic [15:0] nx;
        logic [15:0] rel;
        @(negedge clk);
        pc_cur = pc; op_code = op; rs1_val = r1; rs2_val = r2;
        imm_val = im; imm_sel = sel; br_ofs = ofs;
        if (!sel)                         op2 = r2;
        else if (op == 4'd10 || op == 4'd11) op2 = {16'h0, im};
        else                              op2 = {24'h0, im[7:0]};
        case (op)
            4'd1:  tk = op2 > r1;
            4'd2:  tk = op2 >= r1;
            4'd3:  tk = op2 < r1;
            4'd4:  tk = op2 <= r1;
            4'd5:  tk = op2 == r1;
            4'd6:  tk = op2 != r1;
            4'd7:  tk = 1'b1;
            4'd8:  tk = r1[op2 % 32] == 1'b1;
            4'd9:  tk = r1[op2 % 32] == 1'b0;
            4'd10, 4'd11: tk = 1'b1;
            default: tk = 1'b0;
        endcase
        rel = pc + {{6{ofs[9]}}, ofs};
        if (op == 4'd10 || op == 4'd11) nx = op2[15:0];
        else if (tk)                    nx = rel;
        else                            nx = pc + 16'd1;
        #2;
        chk(tag, "pc_next", {16'h0, pc_next}, {16'h0, nx});
        chk(tag, "br_taken", {31'h0, br_taken}, {31'h0, tk});
        chk(tag, "link_we", {31'h0, link_we}, {31'h0, (op == 4'd11)});
        if (op == 4'd11) chk(tag, "link_val", link_val, {16'h0, pc + 16'd1});
    endtask

    logic [31:0] pat_r [8];
    logic [15:0] pat_i [8];
    logic [9:0]  pat_o [4];
    logic [15:0] pat_p [3];

    initial begin
        pat_r[0] = 32'h0000_0000; pat_r[1] = 32'h0000_0001; pat_r[2] = 32'h0000_0007;
        pat_r[3] = 32'h0000_0008; pat_r[4] = 32'h0000_0009; pat_r[5] = 32'h0000_00FF;
        pat_r[6] = 32'h8000_0000; pat_r[7] = 32'hFFFF_FFFF;
        pat_i[0] = 16'h0000; pat_i[1] = 16'h0001; pat_i[2] = 16'h0007; pat_i[3] = 16'h0008;
        pat_i[4] = 16'h0009; pat_i[5] = 16'h00FF; pat_i[6] = 16'hA508; pat_i[7] = 16'hFFFF;
        pat_o[0] = 10'h005; pat_o[1] = 10'h3FD; pat_o[2] = 10'h1FF; pat_o[3] = 10'h200;
        pat_p[0] = 16'h0000; pat_p[1] = 16'h1234; pat_p[2] = 16'hFFFF;

        pc_cur = 16'h0040; op_code = 4'd0; rs1_val = '0; rs2_val = '0;
        imm_val = '0; imm_sel = 1'b0; br_ofs = '0;
        #2;
        // R1: idle inputs give the sequential address
        chk("R1", "initial pc_next", {16'h0, pc_next}, 32'h0000_0041);
        chk("R1", "initial br_taken", {31'h0, br_taken}, 32'h0);

        // Directed corners
        apply_and_check(16'hFFFF, 4'd7, 0, 0, 0, 1'b0, 10'h001, "R5");   // R5 wrap forward
        apply_and_check(16'hFFFF, 4'd0, 0, 0, 0, 1'b0, 10'h001, "R5");   // R5 fall-through wraps
        apply_and_check(16'h0010, 4'd7, 0, 0, 0, 1'b0, 10'h3F0, "R10");  // R10 back to 0
        apply_and_check(16'h0005, 4'd7, 0, 0, 0, 1'b0, 10'h200, "R10");  // R10 most negative
        apply_and_check(16'h0100, 4'd5, 32'h8, 32'h0, 16'hA508, 1'b1, 10'h010, "R7"); // R7 upper imm ignored
        apply_and_check(16'h0100, 4'd5, 32'h8, 32'h8, 16'h0000, 1'b0, 10'h010, "R7"); // R7 register path
        apply_and_check(16'h0200, 4'd10, 0, 32'hDEAD_BEEF, 16'h1357, 1'b1, 0, "R8");
        apply_and_check(16'h0200, 4'd10, 0, 32'hDEAD_BEEF, 16'h1357, 1'b0, 0, "R8");
        apply_and_check(16'hFFFF, 4'd11, 0, 32'h0000_4444, 16'h0, 1'b0, 0, "R9"); // link wraps to 0

        // R6: every bit position, upper index bits set
        for (int b = 0; b < 32; b++) begin
            for (int k = 0; k < 2; k++) begin
                apply_and_check(16'h0300, k ? 4'd8 : 4'd9, 32'h1 << b, 32'(b + 96), 16'h0, 1'b0, 10'h020, "R6");
                apply_and_check(16'h0300, k ? 4'd8 : 4'd9, ~(32'h1 << b), 32'(b + 224), 16'h0, 1'b0, 10'h020, "R6");
            end
        end

        // Main sweep over all codes
        for (int op = 0; op < 16; op++)
            for (int a = 0; a < 8; a++)
                for (int j = 0; j < 8; j++)
                    for (int s = 0; s < 2; s++)
                        for (int o = 0; o < 4; o++)
                            apply_and_check(pat_p[(a + j + o) % 3], 4'(op), pat_r[a], pat_r[j],
                                            pat_i[j], 1'(s), pat_o[o], tag_of(4'(op)));

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule